// File: doc/BRIEF.md
# Reshapeable Two-Port Block Memory

This block holds a fixed store of 1,152 bits behind one write port and one read port. Each port has its own clock. A static two-bit shape input sets how the store is seen: as 64 words of 18 bits, 128 words of 9 bits, 256 words of 4 bits, or 512 words of 2 bits. Both data buses are 18 bits wide. In the narrower shapes, only the low bits of each bus carry data.

The store is built as 64 rows of 18 bits. The low six address bits pick the row. The address bits above them, limited to the depth of the shape, pick which slice of the row is used. A static read-style input selects one of two read paths. In the first, read data is registered on the read clock and qualified by a read enable. In the second, read data follows the read address with no clock involved.

Wider words are built outside the block. Several copies share the same address lines, and each copy takes its own part of the word. For that to work, every copy must respond the same way to the same address and shape.

Top module: `morph_ram`

## Requirements
- R1: The shape input encodes 0 = 64x18, 1 = 128x9, 2 = 256x4 and 3 = 512x2, and it is held steady outside reset. Address bits [5:0] pick the row. For the 128x9, 256x4 and 512x2 shapes, address bits [6], [7:6] and [8:6] respectively give the slice number k, and slice k occupies row bits [k*w +: w], where w is the word width. Address bits above the shape's depth are ignored, so in 64x18 addresses 5 and 0x145 name the same word.
- R2: A word is stored on the rising write clock only when the write enable is high. With the enable low, the store is left unchanged.
- R3: Write data bits above the shape's width are ignored. In the 256x4 and 512x2 shapes, row bits [17:16] are never altered.
- R4: With registered reads, read data takes the addressed word on the rising read clock when the read enable is high. It holds its value when the read enable is low.
- R5: Read data bits above the shape's width are always zero.
- R6: With combinational reads (read-style input high), read data follows the read address and the stored contents without any read clock edge.
- R7: A registered read of an address on the same edge that writes that address returns the previous contents. The new word is returned by the next read.
- R8: The synchronous read reset clears registered read data to zero. The store itself is not cleared by any reset.
- R9: The write port and the read port operate independently in the same cycle on different addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable, active high |
| wr_addr | input | 9 | Write address |
| wr_data | input | 18 | Write data, low-aligned to the shape's width |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous active-high reset of the read register |
| rd_en | input | 1 | Read enable for registered reads |
| rd_addr | input | 9 | Read address |
| rd_data | output | 18 | Read data, upper bits zero in narrow shapes |
| shape_sel | input | 2 | Static depth-by-width shape |
| comb_read | input | 1 | Static read style: 1 = combinational, 0 = registered |

## Verification
A write takes effect at the rising write edge. A registered read shows its word at the rising read edge that samples the address. The bench therefore drives every input on a falling edge and samples the result on the next falling edge, half a cycle after the single edge that produces it. Combinational reads are checked 1 ns after the read address changes, with no rising edge in between. Read data is checked on the falling edge that follows the write edge, to show the new word appears with no extra cycle. Same-edge write and read checks sample once after the shared edge, for the old word, and then again after the next read edge, for the new word.

// File: rtl/morph_ram_pkg.sv
package morph_ram_pkg;

    localparam int ROW_W     = 18;
    localparam int ROW_CNT   = 64;
    localparam int ROW_AW    = $clog2(ROW_CNT);
    localparam int SHAPE_CNT = 4;
    localparam int SLICE_W   = SHAPE_CNT - 1;
    localparam int ADDR_W    = ROW_AW + SLICE_W;
    localparam int OFF_W     = $clog2(ROW_W);

    typedef enum logic [1:0] {
        SHAPE_64X18  = 2'd0,
        SHAPE_128X9  = 2'd1,
        SHAPE_256X4  = 2'd2,
        SHAPE_512X2  = 2'd3
    } shape_e;

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Where one word lives inside the row array.
    typedef struct packed {
        logic [ROW_AW-1:0] row;
        logic [OFF_W-1:0]  offset;
        row_t              ones;
    } lane_t;

    // Word width of a shape: the row split into 2**shape slices.
    function automatic int shape_width(shape_e s);
        return ROW_W / (1 << int'(s));
    endfunction

    // Low-aligned mask covering one word of the shape.
    function automatic row_t shape_ones(shape_e s);
        logic [ROW_W:0] wide;
        wide = ({{ROW_W{1'b0}}, 1'b1} << shape_width(s)) - 1'b1;
        return wide[ROW_W-1:0];
    endfunction

    // Which upper address bits are meaningful for a shape.
    function automatic logic [SLICE_W-1:0] slice_keep(shape_e s);
        return SLICE_W'((1 << int'(s)) - 1);
    endfunction

    function automatic lane_t decode_lane(addr_t addr, shape_e s);
        lane_t              l;
        logic [SLICE_W-1:0] slice;
        slice    = addr[ADDR_W-1:ROW_AW] & slice_keep(s);
        l.row    = addr[ROW_AW-1:0];
        l.offset = OFF_W'(int'(slice) * shape_width(s));
        l.ones   = shape_ones(s);
        return l;
    endfunction

endpackage

// File: rtl/morph_lane_decode.sv
module morph_lane_decode
    import morph_ram_pkg::*;
(
    input  addr_t  addr,
    input  shape_e shape,
    output lane_t  lane
);

    always_comb begin
        lane = decode_lane(addr, shape);
    end

endmodule

// File: rtl/morph_row_store.sv
module morph_row_store
    import morph_ram_pkg::*;
#(
    parameter int ROWS = ROW_CNT,
    parameter int RW   = ROW_W
)(
    input  logic                     wr_clk,
    input  logic                     wr_en,
    input  lane_t                    wr_lane,
    input  logic [RW-1:0]            wr_data,
    input  logic [$clog2(ROWS)-1:0]  rd_row,
    output logic [RW-1:0]            rd_row_data
);

    localparam int RAW = $clog2(ROWS);

    logic [RW-1:0] rows [ROWS];
    logic [RW-1:0] place_mask;
    logic [RW-1:0] place_data;
    logic [RW-1:0] merged;

    always_comb begin
        place_mask = wr_lane.ones << wr_lane.offset;
        place_data = (wr_data & wr_lane.ones) << wr_lane.offset;
        merged     = (rows[wr_lane.row] & ~place_mask) | place_data;
    end

    for (genvar r = 0; r < ROWS; r++) begin : gen_row
        always_ff @(posedge wr_clk) begin
            if (wr_en && (wr_lane.row == RAW'(r))) begin
                rows[r] <= merged;
            end
        end
    end

    assign rd_row_data = rows[rd_row];

endmodule

// File: rtl/morph_read_path.sv
module morph_read_path
    import morph_ram_pkg::*;
#(
    parameter int RW = ROW_W
)(
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_en,
    input  logic          comb_read,
    input  lane_t         rd_lane,
    input  logic [RW-1:0] row_data,
    output logic [RW-1:0] rd_data
);

    logic [RW-1:0] picked;
    logic [RW-1:0] held;

    always_comb begin
        picked = (row_data >> rd_lane.offset) & rd_lane.ones;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            held <= '0;
        end else if (rd_en) begin
            held <= picked;
        end
    end

    assign rd_data = comb_read ? picked : held;

endmodule

// File: rtl/morph_ram.sv
module morph_ram
    import morph_ram_pkg::*;
(
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ROW_W-1:0]  wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ROW_W-1:0]  rd_data,
    input  logic [1:0]        shape_sel,
    input  logic              comb_read
);

    shape_e shape;
    lane_t  wr_lane;
    lane_t  rd_lane;
    row_t   row_out;

    assign shape = shape_e'(shape_sel);

    morph_lane_decode u_wr_dec (
        .addr  (wr_addr),
        .shape (shape),
        .lane  (wr_lane)
    );

    morph_lane_decode u_rd_dec (
        .addr  (rd_addr),
        .shape (shape),
        .lane  (rd_lane)
    );

    morph_row_store #(
        .ROWS (ROW_CNT),
        .RW   (ROW_W)
    ) u_store (
        .wr_clk      (wr_clk),
        .wr_en       (wr_en),
        .wr_lane     (wr_lane),
        .wr_data     (wr_data),
        .rd_row      (rd_lane.row),
        .rd_row_data (row_out)
    );

    morph_read_path #(
        .RW (ROW_W)
    ) u_read (
        .rd_clk    (rd_clk),
        .rd_rst    (rd_rst),
        .rd_en     (rd_en),
        .comb_read (comb_read),
        .rd_lane   (rd_lane),
        .row_data  (row_out),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/morph_ram_chk.sv
module morph_ram_chk
    import morph_ram_pkg::*;
(
    input logic             rd_clk,
    input logic             rd_rst,
    input logic             rd_en,
    input logic             comb_read,
    input logic [1:0]       shape_sel,
    input logic [ROW_W-1:0] rd_data
);

    // R1: shape and read style do not move outside reset
    assert_shape_static_R1: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $stable({shape_sel, comb_read}))
        else $error("shape or read style changed outside reset");

    // R5: nothing above the shape's width
    assert_upper_zero_R5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_data & ~shape_ones(shape_e'(shape_sel))) == '0)
        else $error("read data bits above word width are set");

    // R4: registered output holds while the read enable is low
    assert_hold_idle_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!comb_read && !rd_en) |=> $stable(rd_data))
        else $error("registered read data moved without read enable");

    // R8: registered output leaves reset cleared
    assert_reset_clear_R8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $fell(rd_rst) |-> (comb_read || rd_data == '0))
        else $error("registered read data not cleared by reset");

endmodule

bind morph_ram morph_ram_chk u_chk (
    .rd_clk    (rd_clk),
    .rd_rst    (rd_rst),
    .rd_en     (rd_en),
    .comb_read (comb_read),
    .shape_sel (shape_sel),
    .rd_data   (rd_data)
);

// File: tb/sim_morph_ram.sv
module sim_morph_ram;

    logic        clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [17:0] wr_data = '0;
    logic        rd_rst = 1'b1;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [17:0] rd_data;
    logic [1:0]  shape_sel = 2'd0;
    logic        comb_read = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    morph_ram u0 (
        .wr_clk    (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_clk    (clk),
        .rd_rst    (rd_rst),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .shape_sel (shape_sel),
        .comb_read (comb_read)
    );

    task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] ones_of(int m);
        int w;
        w = 18 / (1 << m);
        return 18'((1 << w) - 1);
    endfunction

    task automatic restart(int m, logic comb);
        @(negedge clk);
        rd_rst    = 1'b1;
        shape_sel = 2'(m);
        comb_read = comb;
        repeat (2) @(negedge clk);
        rd_rst = 1'b0;
    endtask

    task automatic write_word(logic [8:0] a, logic [17:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_word(logic [8:0] a, output logic [17:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [17:0] v;
        restart(0, 1'b0);
        check("R8 cleared after reset", rd_data, 18'h0);
        write_word(9'd2, 18'h15A3C);
        read_word(9'd2, v);
        check("R4 readback before reset", v, 18'h15A3C);
        restart(0, 1'b0);
        check("R8 cleared again", rd_data, 18'h0);
        read_word(9'd2, v);
        check("R8 store kept over reset", v, 18'h15A3C);
    endtask

    task automatic t_wide;
        logic [17:0] v;
        restart(0, 1'b0);
        write_word(9'd5, 18'h3A5C1);
        write_word(9'd63, 18'h1FFFF);
        read_word(9'd5, v);
        check("R2 wide addr 5", v, 18'h3A5C1);
        read_word(9'd63, v);
        check("R2 wide addr 63", v, 18'h1FFFF);
        read_word(9'h145, v);
        check("R1 upper addr bits ignored", v, 18'h3A5C1);
    endtask

    task automatic t_narrow(int m);
        logic [17:0] v;
        logic [17:0] msk;
        int          slices;
        msk    = ones_of(m);
        slices = 1 << m;
        restart(m, 1'b0);
        for (int k = 0; k < slices; k++) begin
            write_word(9'(10 + 64 * k), (~msk) | (18'(k * 5 + 3) & msk));
        end
        for (int k = 0; k < slices; k++) begin
            read_word(9'(10 + 64 * k), v);
            check($sformatf("R3 R5 shape %0d slice %0d", m, k), v, 18'(k * 5 + 3) & msk);
        end
    endtask

    task automatic t_layout;
        logic [17:0] v;
        logic [17:0] orig;
        orig = 18'h2B5A7;
        restart(0, 1'b0);
        write_word(9'd3, orig);
        restart(3, 1'b0);
        for (int k = 0; k < 8; k++) begin
            read_word(9'(3 + 64 * k), v);
            check($sformatf("R1 512x2 slice %0d", k), v, (orig >> (2 * k)) & 18'h3);
        end
        restart(1, 1'b0);
        read_word(9'd67, v);
        check("R1 128x9 upper slice", v, (orig >> 9) & 18'h1FF);
        restart(2, 1'b0);
        for (int k = 0; k < 4; k++) begin
            write_word(9'(3 + 64 * k), 18'h3FFFF);
        end
        restart(0, 1'b0);
        read_word(9'd3, v);
        check("R3 row bits 17:16 untouched", v, (orig & 18'h30000) | 18'h0FFFF);
    endtask

    task automatic t_enable;
        logic [17:0] v;
        restart(0, 1'b0);
        write_word(9'd7, 18'h0A0A0);
        write_word(9'd8, 18'h05050);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 9'd7; wr_data = 18'h3FFFF;
        @(negedge clk);
        read_word(9'd7, v);
        check("R2 write disabled", v, 18'h0A0A0);
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 9'd8;
        @(negedge clk);
        check("R4 hold with read enable low", rd_data, 18'h0A0A0);
    endtask

    task automatic t_same_edge;
        logic [17:0] v;
        restart(0, 1'b0);
        write_word(9'd20, 18'h11111);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'd20; wr_data = 18'h22222;
        rd_en = 1'b1; rd_addr = 9'd20;
        @(negedge clk);
        check("R7 same edge returns old", rd_data, 18'h11111);
        wr_addr = 9'd21; wr_data = 18'h33333;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R7 R9 next read returns new", rd_data, 18'h22222);
        read_word(9'd21, v);
        check("R9 parallel write landed", v, 18'h33333);
    endtask

    task automatic t_comb;
        restart(2, 1'b1);
        write_word(9'h085, 18'h3FFF9);
        write_word(9'h005, 18'h00006);
        @(negedge clk);
        rd_addr = 9'h085;
        #1;
        check("R6 follows address slice 2", rd_data, 18'h9);
        rd_addr = 9'h005;
        #1;
        check("R6 follows address slice 0", rd_data, 18'h6);
        wr_en = 1'b1; wr_addr = 9'h005; wr_data = 18'h0000C;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 new word seen without read edge", rd_data, 18'hC);
    endtask

    initial begin
        t_reset;
        t_wide;
        for (int m = 0; m < 4; m++) t_narrow(m);
        t_layout;
        t_enable;
        t_same_edge;
        t_comb;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule